// File: doc/BRIEF.md
# VME Block Transfer Boundary Splitter

This block runs the address side of a VME block transfer once the bus is owned. A request carries a start address, a byte count, a transfer kind (single-width block or multiplexed 64-bit block), a beat width and an addressing mode. In incrementing mode, the block steps the address by one beat after every acknowledged beat. It drops the address strobe for a single clock whenever the next address lands on a hardware-fixed span edge. The bus request stays high throughout, so ownership is never given up. In fixed (FIFO) mode, every beat goes to the same address and the span edges are ignored.

Requests arrive over a valid/ready handshake. `req_ready_o` is high only while the block is idle. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. The requester must hold all request fields steady while `req_valid_i` is high and not yet accepted. Back-pressure lasts for the whole transfer, from acceptance until the completion or error pulse.

At the end, the block reports exactly one of three outcomes: a done pulse, an illegal-request pulse, or a bus-error pulse. After a bus error, the count of bytes not yet transferred stays readable.

Top module: `vme_burst_splitter`

## Requirements
- R1: `req_ready_o` is 1 only while no transfer is in progress, and a request is accepted on an edge where `req_valid_i` and `req_ready_o` are both 1.
- R2: The legal combinations are kind 0 (block) with size 1 (16-bit) or 2 (32-bit), and kind 1 (multiplexed) with size 3 (64-bit). Size 0 (8-bit) is never legal. The address and the byte count must both be multiples of the beat width, and the byte count must be non-zero. Any other request produces a one-clock `err_illegal_o` pulse in the cycle after acceptance, and `bus_req_o` stays low.
- R3: After a legal request is accepted, `bus_req_o` rises in the next cycle. `as_o` stays low until `bus_grant_i` is seen high.
- R4: In incrementing mode, the address advances by the beat width (2, 4 or 8 bytes) after each beat acknowledged by `dtack_i`.
- R5: For kind 0, when the next address is a multiple of 256, `as_o` goes low for exactly one clock and then rises again with the new address. `bus_req_o` stays high through this gap.
- R6: For kind 1, the same split happens when the next address is a multiple of 2048, and only then.
- R7: In fixed mode (`req_fixed_i` = 1), every beat presents the start address and no split ever occurs.
- R8: In the cycle after the last beat is acknowledged, `done_o` is high for exactly one clock, `rem_bytes_o` is 0, and `as_o` and `bus_req_o` are both low.
- R9: If `berr_i` is high while a beat is in progress, the transfer ends with a one-clock `err_berr_o` pulse and no `done_o`. `rem_bytes_o` then holds the bytes not transferred, including the failed beat.
- R10: `ds_o` is high only while `as_o` is high, and `addr_o` does not change during a beat's data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_addr_i | input | AW | Start byte address |
| req_bytes_i | input | CW | Byte count |
| req_kind_i | input | 1 | 0 = block, 1 = multiplexed 64-bit block |
| req_size_i | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit |
| req_fixed_i | input | 1 | 1 = fixed (FIFO) addressing |
| bus_req_o | output | 1 | Bus ownership requested or held |
| bus_grant_i | input | 1 | Bus ownership granted |
| as_o | output | 1 | Address strobe, active high |
| ds_o | output | 1 | Data strobe, active high |
| addr_o | output | AW | Current beat address |
| dtack_i | input | 1 | Beat acknowledge |
| berr_i | input | 1 | Bus error on the current beat |
| done_o | output | 1 | Transfer complete pulse |
| err_illegal_o | output | 1 | Request rejected pulse |
| err_berr_o | output | 1 | Transfer ended by bus error pulse |
| rem_bytes_o | output | CW | Bytes not yet transferred |

## Verification
Most internal faults in this block show up at the ports within one beat. A wrong remaining count makes `done_o` arrive early or late, and the beat count no longer matches the byte count. A wrong span edge misplaces the one-clock `as_o` gap, and the beat index where the gap appears shows this on the first crossing. A corrupted address step, or a missed fixed-mode latch, appears on the next `addr_o` presented with `ds_o`. A legality fault shows either as a missing `err_illegal_o` or as an unexpected `bus_req_o` in the very next cycle.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_ADDR,
    ST_DATA,
    ST_GAP
  } vbs_state_e;

  localparam logic [1:0] SZ_D08 = 2'd0;
  localparam logic [1:0] SZ_D16 = 2'd1;
  localparam logic [1:0] SZ_D32 = 2'd2;
  localparam logic [1:0] SZ_D64 = 2'd3;

  localparam logic KIND_BLK  = 1'b0;
  localparam logic KIND_MBLK = 1'b1;
endpackage

// File: rtl/vbs_req_check.sv
module vbs_req_check
  import vbs_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          kind_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] bytes_i,
  output logic          legal_o,
  output logic [3:0]    beat_o
);
  logic       combo_ok;
  logic       addr_ok;
  logic       count_ok;
  logic [3:0] low_mask;

  always_comb begin
    unique case (size_i)
      SZ_D16:  beat_o = 4'd2;
      SZ_D32:  beat_o = 4'd4;
      SZ_D64:  beat_o = 4'd8;
      default: beat_o = 4'd1;
    endcase
  end

  assign low_mask = beat_o - 4'd1;

  always_comb begin
    if (kind_i == KIND_BLK) combo_ok = (size_i == SZ_D16) || (size_i == SZ_D32);
    else                    combo_ok = (size_i == SZ_D64);
  end

  assign addr_ok  = (addr_i[3:0] & low_mask) == 4'd0;
  assign count_ok = (bytes_i != '0) && ((bytes_i[3:0] & low_mask) == 4'd0);
  assign legal_o  = combo_ok && addr_ok && count_ok;
endmodule

// File: rtl/vbs_addr_gen.sv
module vbs_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] bytes_i,
  input  logic [3:0]    beat_i,
  input  logic          fixed_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] addr_next_o,
  output logic [CW-1:0] rem_o,
  output logic          last_o,
  output logic          fixed_o
);
  logic [3:0]    beat_q;
  logic [AW-1:0] beat_a;
  logic [CW-1:0] beat_c;

  assign beat_a      = {{(AW-4){1'b0}}, beat_q};
  assign beat_c      = {{(CW-4){1'b0}}, beat_q};
  assign addr_next_o = addr_o + beat_a;
  assign last_o      = (rem_o == beat_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      rem_o   <= '0;
      beat_q  <= 4'd1;
      fixed_o <= 1'b0;
    end else if (load_i) begin
      addr_o  <= addr_i;
      rem_o   <= bytes_i;
      beat_q  <= beat_i;
      fixed_o <= fixed_i;
    end else if (step_i) begin
      rem_o <= rem_o - beat_c;
      if (!fixed_o) addr_o <= addr_next_o;
    end
  end
endmodule

// File: rtl/vbs_boundary.sv
module vbs_boundary
  import vbs_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BLK_SPAN  = 256,
  parameter int MBLK_SPAN = 2048
) (
  input  logic [AW-1:0] addr_next_i,
  input  logic          kind_i,
  input  logic          fixed_i,
  output logic          edge_o
);
  localparam int BLK_LSB  = $clog2(BLK_SPAN);
  localparam int MBLK_LSB = $clog2(MBLK_SPAN);

  logic blk_edge;
  logic mblk_edge;

  assign blk_edge  = addr_next_i[BLK_LSB-1:0] == '0;
  assign mblk_edge = addr_next_i[MBLK_LSB-1:0] == '0;
  assign edge_o    = !fixed_i && ((kind_i == KIND_MBLK) ? mblk_edge : blk_edge);
endmodule

// File: rtl/vme_burst_splitter.sv
module vme_burst_splitter
  import vbs_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CW        = 16,
  parameter int BLK_SPAN  = 256,
  parameter int MBLK_SPAN = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [CW-1:0] req_bytes_i,
  input  logic          req_kind_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_fixed_i,
  output logic          bus_req_o,
  input  logic          bus_grant_i,
  output logic          as_o,
  output logic          ds_o,
  output logic [AW-1:0] addr_o,
  input  logic          dtack_i,
  input  logic          berr_i,
  output logic          done_o,
  output logic          err_illegal_o,
  output logic          err_berr_o,
  output logic [CW-1:0] rem_bytes_o
);
  vbs_state_e    state_q, state_d;
  logic          legal;
  logic [3:0]    beat;
  logic          accept;
  logic          load;
  logic          step;
  logic          last;
  logic          at_edge;
  logic          fixed_q;
  logic          kind_q;
  logic [AW-1:0] addr_next;

  vbs_req_check #(.AW(AW), .CW(CW)) i_check (
    .kind_i  (req_kind_i),
    .size_i  (req_size_i),
    .addr_i  (req_addr_i),
    .bytes_i (req_bytes_i),
    .legal_o (legal),
    .beat_o  (beat)
  );

  vbs_addr_gen #(.AW(AW), .CW(CW)) i_agen (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .addr_i      (req_addr_i),
    .bytes_i     (req_bytes_i),
    .beat_i      (beat),
    .fixed_i     (req_fixed_i),
    .step_i      (step),
    .addr_o      (addr_o),
    .addr_next_o (addr_next),
    .rem_o       (rem_bytes_o),
    .last_o      (last),
    .fixed_o     (fixed_q)
  );

  vbs_boundary #(.AW(AW), .BLK_SPAN(BLK_SPAN), .MBLK_SPAN(MBLK_SPAN)) i_bnd (
    .addr_next_i (addr_next),
    .kind_i      (kind_q),
    .fixed_i     (fixed_q),
    .edge_o      (at_edge)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign load        = accept && legal;
  assign step        = (state_q == ST_DATA) && dtack_i && !berr_i;
  assign bus_req_o   = (state_q != ST_IDLE);
  assign as_o        = (state_q == ST_ADDR) || (state_q == ST_DATA);
  assign ds_o        = (state_q == ST_DATA);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load) state_d = ST_ARB;
      ST_ARB:  if (bus_grant_i) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: begin
        if (berr_i)           state_d = ST_IDLE;
        else if (dtack_i) begin
          if (last)           state_d = ST_IDLE;
          else if (at_edge)   state_d = ST_GAP;
          else                state_d = ST_ADDR;
        end
      end
      ST_GAP:  state_d = ST_ADDR;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      kind_q        <= 1'b0;
      done_o        <= 1'b0;
      err_illegal_o <= 1'b0;
      err_berr_o    <= 1'b0;
    end else begin
      state_q       <= state_d;
      if (load) kind_q <= req_kind_i;
      done_o        <= step && last;
      err_illegal_o <= accept && !legal;
      err_berr_o    <= (state_q == ST_DATA) && berr_i;
    end
  end
endmodule

// File: rtl/vbs_checker.sv
module vbs_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          as_o,
  input logic          ds_o,
  input logic          bus_req_o,
  input logic          done_o,
  input logic          err_illegal_o,
  input logic [AW-1:0] addr_o,
  input logic          fixed_q
);
  AST_DS_INSIDE_AS: assert property (@(posedge clk) disable iff (!rst_n)
    ds_o |-> as_o); // R10
  AST_ADDR_STEADY_DS: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_o && $past(as_o)) |-> $stable(addr_o)); // R10
  AST_AS_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    as_o |-> bus_req_o); // R3
  AST_REQ_BEFORE_AS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_o) |-> !as_o); // R3
  AST_GAP_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(as_o) && bus_req_o) |=> as_o); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!bus_req_o && !as_o)); // R8
  AST_ILLEGAL_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal_o |-> !bus_req_o); // R2
  AST_FIFO_ADDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed_q && bus_req_o && $past(bus_req_o)) |-> $stable(addr_o)); // R7
endmodule

bind vme_burst_splitter vbs_checker #(.AW(AW)) i_vbs_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .as_o          (as_o),
  .ds_o          (ds_o),
  .bus_req_o     (bus_req_o),
  .done_o        (done_o),
  .err_illegal_o (err_illegal_o),
  .addr_o        (addr_o),
  .fixed_q       (fixed_q)
);

// File: tb/test_vme_burst_splitter.sv
`timescale 1ns/1ps
module test_vme_burst_splitter;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [AW-1:0] req_addr_i = '0;
  logic [CW-1:0] req_bytes_i = '0;
  logic          req_kind_i = 1'b0;
  logic [1:0]    req_size_i = 2'd0;
  logic          req_fixed_i = 1'b0;
  logic          bus_req_o;
  logic          bus_grant_i = 1'b1;
  logic          as_o, ds_o;
  logic [AW-1:0] addr_o;
  logic          dtack_i = 1'b0;
  logic          berr_i = 1'b0;
  logic          done_o, err_illegal_o, err_berr_o;
  logic [CW-1:0] rem_bytes_o;

  int compared = 0;
  int mismatched = 0;
  int berr_at = -1;
  int tot_beats = 0, tot_splits = 0, tot_gaps = 0;
  int beat_idx = 0;
  logic prev_as = 1'b0, seen_as = 1'b0;
  logic [AW-1:0] alog [64];
  logic got_done, got_berr, got_ill;

  always #5 clk = ~clk;

  vme_burst_splitter #(.AW(AW), .CW(CW)) i_vme_burst_splitter (.*);

  // bus slave and monitor, all at the falling edge
  always @(negedge clk) begin
    dtack_i = ds_o && (beat_idx != berr_at);
    berr_i  = ds_o && (beat_idx == berr_at);
    if (ds_o) begin
      if (beat_idx < 64) alog[beat_idx] = addr_o;
      beat_idx++;
      tot_beats++;
    end
    if (bus_req_o && !as_o && prev_as) tot_splits++;
    if (bus_req_o && !as_o && seen_as) tot_gaps++;
    if (as_o) seen_as = 1'b1;
    if (!bus_req_o) begin seen_as = 1'b0; beat_idx = 0; end
    prev_as = as_o;
  end

  task automatic chk(string req, longint act, longint exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic kind, input logic [1:0] size, input logic [AW-1:0] a,
                     input logic [CW-1:0] n, input logic fx, input int berr_beat,
                     output int beats, output int splits, output int gaps);
    int b0, s0, g0;
    @(negedge clk);
    b0 = tot_beats; s0 = tot_splits; g0 = tot_gaps;
    berr_at = berr_beat;
    req_kind_i = kind; req_size_i = size; req_addr_i = a;
    req_bytes_i = n; req_fixed_i = fx; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    got_done = 1'b0; got_berr = 1'b0; got_ill = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (done_o) got_done = 1'b1;
      if (err_berr_o) got_berr = 1'b1;
      if (err_illegal_o) got_ill = 1'b1;
      if (got_done || got_berr || got_ill) break;
      @(negedge clk);
    end
    beats = tot_beats - b0; splits = tot_splits - s0; gaps = tot_gaps - g0;
    berr_at = -1;
  endtask

  task automatic t_reset;
    chk("R1 ready after reset", req_ready_o, 1);
    chk("R3 no bus_req after reset", bus_req_o, 0);
    chk("R10 no as after reset", as_o, 0);
    chk("R8 no done after reset", done_o, 0);
  endtask

  task automatic t_blk32_incr;
    int b, s, g;
    run(1'b0, 2'd2, 32'h0F0, 16'd64, 1'b0, -1, b, s, g);
    chk("R8 done pulse", got_done, 1);
    chk("R8 rem zero", rem_bytes_o, 0);
    chk("R8 bus released", bus_req_o, 0);
    chk("R4 beat count", b, 16);
    chk("R4 first addr", alog[0], 32'h0F0);
    chk("R4 addr step", alog[1], 32'h0F4);
    chk("R5 addr after edge", alog[4], 32'h100);
    chk("R4 last addr", alog[15], 32'h12C);
    chk("R5 one split", s, 1);
    chk("R5 gap one clock", g, 1);
    @(negedge clk);
    chk("R8 done one clock", done_o, 0);
  endtask

  task automatic t_blk_two_edges;
    int b, s, g;
    run(1'b0, 2'd2, 32'h0F8, 16'd272, 1'b0, -1, b, s, g);
    chk("R5 beats across two edges", b, 68);
    chk("R5 two splits", s, 2);
    chk("R5 two gap clocks", g, 2);
  endtask

  task automatic t_blk16;
    int b, s, g;
    run(1'b0, 2'd1, 32'h1FE, 16'd8, 1'b0, -1, b, s, g);
    chk("R4 D16 beats", b, 4);
    chk("R4 D16 step", alog[1], 32'h200);
    chk("R4 D16 last", alog[3], 32'h204);
    chk("R5 D16 split", s, 1);
  endtask

  task automatic t_mblk;
    int b, s, g;
    run(1'b1, 2'd3, 32'h7E0, 16'd128, 1'b0, -1, b, s, g);
    chk("R6 beats", b, 16);
    chk("R6 addr at edge", alog[4], 32'h800);
    chk("R6 last addr", alog[15], 32'h858);
    chk("R6 one split", s, 1);
    run(1'b1, 2'd3, 32'h0F0, 16'd64, 1'b0, -1, b, s, g);
    chk("R6 no split at 256 edge", s, 0);
    chk("R6 done", got_done, 1);
  endtask

  task automatic t_fifo;
    int b, s, g;
    run(1'b0, 2'd2, 32'h0FC, 16'd32, 1'b1, -1, b, s, g);
    chk("R7 beats", b, 8);
    chk("R7 addr fixed first", alog[0], 32'h0FC);
    chk("R7 addr fixed last", alog[7], 32'h0FC);
    chk("R7 no split", s, 0);
    run(1'b1, 2'd3, 32'h7F8, 16'd24, 1'b1, -1, b, s, g);
    chk("R7 mblk fixed", alog[2], 32'h7F8);
    chk("R7 mblk no split", s, 0);
  endtask

  task automatic t_illegal;
    int b, s, g;
    run(1'b0, 2'd0, 32'h0, 16'd4, 1'b0, -1, b, s, g);
    chk("R2 D08 block rejected", got_ill, 1);
    chk("R2 no bus_req", bus_req_o, 0);
    chk("R2 no beats", b, 0);
    run(1'b1, 2'd2, 32'h800, 16'd16, 1'b0, -1, b, s, g);
    chk("R2 mblk D32 rejected", got_ill, 1);
    run(1'b0, 2'd3, 32'h800, 16'd16, 1'b0, -1, b, s, g);
    chk("R2 block D64 rejected", got_ill, 1);
    run(1'b1, 2'd3, 32'h804, 16'd16, 1'b0, -1, b, s, g);
    chk("R2 misaligned rejected", got_ill, 1);
    run(1'b0, 2'd2, 32'h100, 16'd6, 1'b0, -1, b, s, g);
    chk("R2 odd count rejected", got_ill, 1);
    run(1'b0, 2'd1, 32'h100, 16'd0, 1'b0, -1, b, s, g);
    chk("R2 zero count rejected", got_ill, 1);
    chk("R2 no beats on reject", b, 0);
  endtask

  task automatic t_berr;
    int b, s, g;
    run(1'b0, 2'd2, 32'h0, 16'd32, 1'b0, 2, b, s, g);
    chk("R9 berr pulse", got_berr, 1);
    chk("R9 no done", got_done, 0);
    chk("R9 remaining", rem_bytes_o, 24);
    chk("R9 bus released", bus_req_o, 0);
  endtask

  task automatic t_grant_wait;
    int b, s, g;
    bus_grant_i = 1'b0;
    @(negedge clk);
    req_kind_i = 1'b0; req_size_i = 2'd2; req_addr_i = 32'h40;
    req_bytes_i = 16'd8; req_fixed_i = 1'b0; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R3 bus_req raised", bus_req_o, 1);
    chk("R1 ready low busy", req_ready_o, 0);
    repeat (4) @(negedge clk);
    chk("R3 no as without grant", as_o, 0);
    chk("R3 still requesting", bus_req_o, 1);
    bus_grant_i = 1'b1;
    for (int i = 0; i < 50 && !done_o; i++) @(negedge clk);
    chk("R3 completes after grant", done_o, 1);
    run(1'b0, 2'd2, 32'h40, 16'd8, 1'b0, -1, b, s, g);
    chk("R1 next request accepted", b, 2);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_blk32_incr();
    t_blk_two_edges();
    t_blk16();
    t_mblk();
    t_fifo();
    t_illegal();
    t_berr();
    t_grant_wait();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule